// File: doc/BRIEF.md
# Dual-Mode Sample Demultiplexer for a Converter Output

This block sits behind an 8-bit conversion core and turns one stream of codes, one code per sample clock, into data on two output ports plus a clock for whatever captures them. It has two output arrangements. In the half-rate arrangement, consecutive samples are paired. The pair is presented together on the two ports once every two sample clocks, and a divide-by-two clock goes out for downstream capture. In the full-rate arrangement, a new code appears on every sample clock, and the clock output is the sample clock inverted.

The divide-by-two stage has its own synchronous active-low reset. Pulsing it on several units at once gives them the same divider phase. The arrangement is chosen by a select input, which is only taken in while a reset is applied. A polarity input can turn every output bit over. The block also has a synchronous active-high reset that clears all of its state.

Top module: `adc_sample_demux`

## Requirements
- R1: `mode_sel` is loaded into the block only on clock edges where `rst` is high or `div_rst_n` is low (1 = half-rate, 0 = full-rate). Changing `mode_sel` while both resets are inactive has no effect on the clock output or on port updates.
- R2: In half-rate mode, `clk_out` is the divided clock. It is low on the first edge after any reset and inverts on every later clock edge while `div_rst_n` is high.
- R3: In half-rate mode, on each edge where the divided clock is high, `p1_data` takes the code captured on the previous edge and `p2_data` takes the code captured two edges earlier. On the other edges both ports hold their values.
- R4: In full-rate mode, `clk_out` is the inverse of `clk`.
- R5: In full-rate mode, on every edge `p1_data` takes the code captured on the previous edge and `p2_data` takes the previous value of `p1_data`.
- R6: While `div_rst_n` is low at a clock edge, the divided clock is forced low and both ports keep their values.
- R7: Each code is captured on a clock edge. When `code_pos` is 1 the code is `din` unchanged; when `code_pos` is 0 it is `~din` (all bits inverted). So with `din` = 8'hFF the port shows 8'hFF or 8'h00.
- R8: When `rst` is high at a clock edge, the ports, the divided clock and the capture stage are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| div_rst_n | input | 1 | Synchronous active-low reset of the divider phase |
| mode_sel | input | 1 | Output arrangement: 1 half-rate pairs, 0 full-rate |
| code_pos | input | 1 | 1 passes codes unchanged, 0 inverts every bit |
| din | input | DW | Conversion code, one per sample clock |
| p1_data | output | DW | Port 1: later sample of a pair, or current sample |
| p2_data | output | DW | Port 2: earlier sample of a pair, or delayed sample |
| clk_out | output | 1 | Divided clock or inverted sample clock |

## Verification
Random codes with a polarity that changes on every cycle are run in both modes. This shows whether the earlier and later samples of a pair land on the correct ports, and whether polarity is taken at the capture edge rather than at the output. Directed all-ones codes under each polarity separate plain from inverted output. Toggling the mode select with no reset shows whether it is latched only under reset. Divider resets of varying length, placed at both divider phases, together with a full reset in the middle of a run, show whether the ports hold, whether the divided clock is forced low, and whether pairing restarts on the correct phase.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } out_mode_e;
endpackage

// File: rtl/code_capture.sv
module code_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          code_pos,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] code_q
);
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_pos ? din : (din ^ ALL_ONES);
  end
endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import adc_demux_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      div_rst_n,
  input  logic      mode_sel,
  output out_mode_e mode_q,
  output logic      div_q
);
  always_ff @(posedge clk) begin
    if (rst || !div_rst_n) begin
      div_q  <= 1'b0;
      mode_q <= out_mode_e'(mode_sel);
    end else begin
      div_q  <= ~div_q;
    end
  end
endmodule

// File: rtl/lane_router.sv
module lane_router
  import adc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  out_mode_e     mode,
  input  logic          div_q,
  input  logic [DW-1:0] code_q,
  output logic [DW-1:0] p1_q,
  output logic [DW-1:0] p2_q
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else if (run) begin
      if (mode == MODE_HALF) begin
        if (!div_q) begin
          hold_q <= code_q;
        end else begin
          p1_q <= code_q;
          p2_q <= hold_q;
        end
      end else begin
        p1_q <= code_q;
        p2_q <= p1_q;
      end
    end
  end
endmodule

// File: rtl/adc_sample_demux.sv
module adc_sample_demux
  import adc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_rst_n,
  input  logic          mode_sel,
  input  logic          code_pos,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] p1_data,
  output logic [DW-1:0] p2_data,
  output logic          clk_out
);
  logic [DW-1:0] code_q;
  out_mode_e     mode_q;
  logic          div_q;

  code_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .code_pos(code_pos), .din(din), .code_q(code_q)
  );

  phase_gen u_phase (
    .clk(clk), .rst(rst), .div_rst_n(div_rst_n), .mode_sel(mode_sel),
    .mode_q(mode_q), .div_q(div_q)
  );

  lane_router #(.DW(DW)) u_route (
    .clk(clk), .rst(rst), .run(div_rst_n), .mode(mode_q), .div_q(div_q),
    .code_q(code_q), .p1_q(p1_data), .p2_q(p2_data)
  );

  assign clk_out = (mode_q == MODE_HALF) ? div_q : ~clk;
endmodule

// File: rtl/adc_sample_demux_chk.sv
module adc_sample_demux_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          div_rst_n,
  input logic          mode_q,
  input logic          div_q,
  input logic [DW-1:0] p1_data,
  input logic [DW-1:0] p2_data
);
  // R6
  div_low_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !div_rst_n |=> !div_q);
  // R6
  ports_hold_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !div_rst_n |=> ($stable(p1_data) && $stable(p2_data)));
  // R2
  div_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    div_rst_n |=> (div_q != $past(div_q)));
  // R3
  half_idle_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !div_q) |=> ($stable(p1_data) && $stable(p2_data)));
  // R5
  full_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && div_rst_n) |=> (p2_data == $past(p1_data)));
  // R1
  mode_locked_chk: assert property (@(posedge clk) disable iff (rst)
    div_rst_n |=> $stable(mode_q));
endmodule

bind adc_sample_demux adc_sample_demux_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .div_rst_n(div_rst_n), .mode_q(mode_q),
  .div_q(div_q), .p1_data(p1_data), .p2_data(p2_data)
);

// File: tb/adc_sample_demux_test.sv
module adc_sample_demux_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_rst_n = 1'b0;
  logic       mode_sel = 1'b1;
  logic       code_pos = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] p1_data, p2_data;
  logic       clk_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic       m_mode, m_div;
  logic [7:0] last, last2, ep1, ep2;

  always #4 clk = ~clk;

  adc_sample_demux #(.DW(8)) uut (
    .clk(clk), .rst(rst), .div_rst_n(div_rst_n), .mode_sel(mode_sel),
    .code_pos(code_pos), .din(din), .p1_data(p1_data), .p2_data(p2_data),
    .clk_out(clk_out)
  );

  function automatic logic [7:0] conv(input logic [7:0] d, input logic pol);
    return pol ? d : ~d;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input logic [7:0] d, input logic pol, input logic dr,
                      input logic sel, input logic r, input string focus);
    string tag;
    logic [7:0] cap;
    din = d; code_pos = pol; div_rst_n = dr; mode_sel = sel; rst = r;
    @(posedge clk);
    cap = r ? 8'h00 : conv(d, pol);
    if (r) begin
      m_mode = sel; m_div = 1'b0; ep1 = 8'h00; ep2 = 8'h00;
    end else if (!dr) begin
      m_mode = sel; m_div = 1'b0;
    end else begin
      if (m_mode) begin
        if (m_div) begin ep1 = last; ep2 = last2; end
      end else begin
        ep2 = ep1; ep1 = last;
      end
      m_div = ~m_div;
    end
    last2 = last; last = cap;
    if (focus != "") tag = focus;
    else if (r) tag = "R8";
    else if (!dr) tag = "R6";
    else if (m_mode) tag = "R3";
    else tag = "R5";
    #2;
    chk(tag, "p1_data", p1_data, ep1);
    chk(tag, "p2_data", p2_data, ep2);
    chk(m_mode ? "R2" : "R4", "clk_out(high phase)", {7'd0, clk_out},
        {7'd0, m_mode ? m_div : 1'b0});
    #4;
    chk(m_mode ? "R2" : "R4", "clk_out(low phase)", {7'd0, clk_out},
        {7'd0, m_mode ? m_div : 1'b1});
  endtask

  task automatic run_random(input int cycles, input logic sel, input int rst_pct);
    for (int i = 0; i < cycles; i++) begin
      logic dr;
      dr = ($urandom_range(99) >= rst_pct);
      tick(8'($urandom), 1'($urandom), dr, sel, 1'b0, "");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_mode = 1'b1; m_div = 1'b0;
    last = '0; last2 = '0; ep1 = '0; ep2 = '0;
    // R8: full reset with half-rate selected
    tick(8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    tick(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
    // R6: divider reset held after full reset
    tick(8'h11, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    tick(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    // half-rate random with per-cycle polarity
    run_random(300, 1'b1, 0);
    // R1: select flipped with no reset, half-rate must persist
    for (int i = 0; i < 20; i++) tick(8'($urandom), 1'b1, 1'b1, 1'b0, 1'b0, "R1");
    // enter full-rate through a divider reset
    tick(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    tick(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    // R7: directed polarity corners
    for (int i = 0; i < 3; i++) tick(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "");
    chk("R7", "p1 full-scale plain", p1_data, 8'hFF);
    for (int i = 0; i < 3; i++) tick(8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, "");
    chk("R7", "p1 full-scale inverted", p1_data, 8'h00);
    for (int i = 0; i < 3; i++) tick(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "");
    chk("R7", "p1 bottom-scale inverted", p1_data, 8'hFF);
    // full-rate random with occasional divider resets
    run_random(300, 1'b0, 5);
    // R1: select flipped to half-rate with no reset, full-rate must persist
    for (int i = 0; i < 20; i++) tick(8'($urandom), 1'b1, 1'b1, 1'b1, 1'b0, "R1");
    // back to half-rate, random resets of any length and phase
    tick(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    run_random(400, 1'b1, 8);
    // R8: full reset mid-run, then resume half-rate
    tick(8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    run_random(100, 1'b1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule